// File: doc/BRIEF.md
# Serial Link Failure Monitor

This block sits beside the framing logic of a multi-lane serial link and decides when the link has to be torn down. It takes a code-violation pulse from each lane, one alignment-loss indication for the bonded lanes, overflow flags from the transmit and receive FIFOs, and a flag raised when the transmitter has been asked to send an illegal control (K) character. Code violations from all lanes are summed in a saturating counter. The count is compared against a programmable threshold and is cleared after a programmable run of error-free cycles. Each of the other conditions trips the link on its own.

When a failure is declared, the block holds its local link logic in reset for a fixed number of cycles. For that whole time it keeps requesting a reset from the far end, so the request still gets through if some symbols are corrupted. It then waits until every lane reports sync before it reports the link up again. A reset request from the far end is handled the same way as a local failure. A sticky cause vector records every condition that was active when the latest failure was declared. It stays until the next failure or until it is cleared.

Top module: `lnk_fail_mon`

## Requirements
- R1: While `rst_n` is low and on its release, `link_up`, `link_rst` and `peer_rst_out` are 0, `fail_cause` is 0, and the monitor is in the sync-wait state.
- R2: In the up state, each cycle adds the number of asserted `lane_cv` bits to the error count. When the count is greater than `err_thresh`, the next clock edge declares a failure.
- R3: The error count saturates at 255 and does not wrap.
- R4: Each cycle in the up state with no `lane_cv` bit set extends a quiet run. When the quiet run reaches `clean_win` cycles, the count is cleared. A `clean_win` of 0 disables this clearing.
- R5: In the up state, each of `align_lost`, `tx_fifo_ovf`, `rx_fifo_ovf` and `bad_k_req` declares a failure at the next clock edge.
- R6: A failure puts the block in a one-cycle fail state (`link_rst`=1, `peer_rst_out`=0). It then enters a reset hold (`link_rst`=1, `peer_rst_out`=1) and then the sync-wait state (`link_rst`=0, `link_up`=0).
- R7: `peer_rst_out` stays high for exactly `HOLD_CYC` (16) consecutive cycles for each failure.
- R8: The block leaves sync-wait for the up state (`link_up`=1) at the first clock edge at which every `lane_sync` bit is 1, and at no other edge.
- R9: `peer_rst_in` in the up state starts the same fail and reset sequence as a local failure.
- R10: Outside the up state, the failure conditions, `lane_cv` and `peer_rst_in` have no effect. The error count is held at zero and `fail_cause` does not change.
- R11: `fail_cause` bit 0 is error-count, bit 1 alignment loss, bit 2 transmit overflow, bit 3 receive overflow, bit 4 illegal K, bit 5 far-end request. When a failure is declared, it is loaded with all sources active in that cycle, replacing the previous value. It then holds until the next failure or a clear.
- R12: `cause_clr` clears `fail_cause` at the next edge. If a failure is declared in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_cv | input | LANES | Per-lane code-violation pulse |
| lane_sync | input | LANES | Per-lane sync achieved |
| align_lost | input | 1 | Bonded lanes out of alignment |
| tx_fifo_ovf | input | 1 | Transmit FIFO overflow |
| rx_fifo_ovf | input | 1 | Receive FIFO overflow |
| bad_k_req | input | 1 | Illegal K character requested for transmission |
| peer_rst_in | input | 1 | Reset request received from the far end |
| err_thresh | input | CNT_W | Error count threshold |
| clean_win | input | WIN_W | Error-free cycles that clear the count (0 = never) |
| cause_clr | input | 1 | Clear the cause vector |
| link_up | output | 1 | Link operational |
| link_rst | output | 1 | Reset for the local link logic |
| peer_rst_out | output | 1 | Reset request to the far end |
| fail_cause | output | 6 | Sticky cause of the latest failure |

## Verification
The bench builds the block with its default parameters: 4 lanes, an 8-bit count, a 16-bit window and a 16-cycle hold. With four lanes the full-scale count of 255 is reached in 64 cycles of all-lane violations, so saturation and the threshold at 254 and 255 can be tested directly. The small thresholds 0 to 4 are swept against every injected error count up to two past the threshold. The 16-cycle hold keeps the reset sequence short enough to count cycle by cycle for every failure source.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
  typedef enum logic [1:0] {
    ST_UP    = 2'd0,
    ST_FAIL  = 2'd1,
    ST_RESET = 2'd2,
    ST_WSYNC = 2'd3
  } lfm_state_e;

  localparam int unsigned SRC_N     = 6;
  localparam int unsigned SRC_PHY   = 0;
  localparam int unsigned SRC_ALIGN = 1;
  localparam int unsigned SRC_TXOV  = 2;
  localparam int unsigned SRC_RXOV  = 3;
  localparam int unsigned SRC_BADK  = 4;
  localparam int unsigned SRC_PEER  = 5;
endpackage

// File: rtl/lfm_err_count.sv
module lfm_err_count #(
  parameter int unsigned LANES = 4,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LANES-1:0] lane_cv,
  input  logic [CNT_W-1:0] thresh,
  input  logic [WIN_W-1:0] clean_win,
  output logic             trip
);
  localparam int unsigned PW = $clog2(LANES + 1);

  logic [PW-1:0]    pop;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WIN_W-1:0] quiet_q, quiet_d;
  logic             win_full;
  logic             cnt_en;
  logic             quiet_en;

  // number of lanes reporting a violation this cycle
  always_comb begin
    pop = '0;
    for (int i = 0; i < LANES; i++) begin
      pop = pop + PW'(lane_cv[i]);
    end
  end

  always_comb begin
    sum      = {1'b0, cnt_q} + (CNT_W+1)'(pop);
    win_full = (clean_win != '0) && (quiet_q == clean_win - WIN_W'(1));
    if (!run) begin
      cnt_d   = '0;
      quiet_d = '0;
    end else if (|lane_cv) begin
      cnt_d   = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      quiet_d = '0;
    end else if (win_full) begin
      cnt_d   = '0;
      quiet_d = '0;
    end else begin
      cnt_d   = cnt_q;
      quiet_d = quiet_q + WIN_W'(1);
    end
    cnt_en   = (cnt_d != cnt_q);
    quiet_en = (quiet_d != quiet_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      quiet_q <= '0;
    end else begin
      if (cnt_en)   cnt_q   <= cnt_d;
      if (quiet_en) quiet_q <= quiet_d;
    end
  end

  assign trip = run && (cnt_q > thresh);
endmodule

// File: rtl/lfm_seq.sv
module lfm_seq
  import lfm_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fail_req,
  input  logic       all_sync,
  output lfm_state_e state
);
  localparam int unsigned HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  lfm_state_e    st_q, st_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          hold_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_UP:    if (fail_req) st_d = ST_FAIL;
      ST_FAIL:  st_d = ST_RESET;
      ST_RESET: if (hold_q == HOLD_LAST) st_d = ST_WSYNC;
      ST_WSYNC: if (all_sync) st_d = ST_UP;
      default:  st_d = ST_WSYNC;
    endcase
    hold_d  = (st_q == ST_RESET) ? hold_q + HW'(1) : '0;
    hold_en = (st_q == ST_RESET) || (hold_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_WSYNC;
      hold_q <= '0;
    end else begin
      st_q <= st_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/lfm_cause.sv
module lfm_cause
  import lfm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             clr,
  input  logic [SRC_N-1:0] src,
  output logic [SRC_N-1:0] cause
);
  logic [SRC_N-1:0] cause_q, cause_d;
  logic             cause_en;

  always_comb begin
    cause_en = capture || clr;
    if (capture)  cause_d = src;
    else          cause_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause = cause_q;
endmodule

// File: rtl/lnk_fail_mon.sv
module lnk_fail_mon
  import lfm_pkg::*;
#(
  parameter int unsigned LANES    = 4,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned WIN_W    = 16,
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_cv,
  input  logic [LANES-1:0] lane_sync,
  input  logic             align_lost,
  input  logic             tx_fifo_ovf,
  input  logic             rx_fifo_ovf,
  input  logic             bad_k_req,
  input  logic             peer_rst_in,
  input  logic [CNT_W-1:0] err_thresh,
  input  logic [WIN_W-1:0] clean_win,
  input  logic             cause_clr,
  output logic             link_up,
  output logic             link_rst,
  output logic             peer_rst_out,
  output logic [5:0]       fail_cause
);
  lfm_state_e       state;
  logic             in_up;
  logic             phy_trip;
  logic [SRC_N-1:0] src;
  logic             fail_any;

  assign in_up = (state == ST_UP);

  lfm_err_count #(
    .LANES(LANES),
    .CNT_W(CNT_W),
    .WIN_W(WIN_W)
  ) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (in_up),
    .lane_cv   (lane_cv),
    .thresh    (err_thresh),
    .clean_win (clean_win),
    .trip      (phy_trip)
  );

  always_comb begin
    src            = '0;
    src[SRC_PHY]   = phy_trip;
    src[SRC_ALIGN] = align_lost;
    src[SRC_TXOV]  = tx_fifo_ovf;
    src[SRC_RXOV]  = rx_fifo_ovf;
    src[SRC_BADK]  = bad_k_req;
    src[SRC_PEER]  = peer_rst_in;
    fail_any       = in_up && (|src);
  end

  lfm_seq #(
    .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fail_req (fail_any),
    .all_sync (&lane_sync),
    .state    (state)
  );

  lfm_cause u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (fail_any),
    .clr     (cause_clr),
    .src     (src),
    .cause   (fail_cause)
  );

  assign link_up      = in_up;
  assign link_rst     = (state == ST_FAIL) || (state == ST_RESET);
  assign peer_rst_out = (state == ST_RESET);
endmodule

// File: rtl/lfm_chk.sv
module lfm_chk #(
  parameter int unsigned LANES    = 4,
  parameter int unsigned HOLD_CYC = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] lane_sync,
  input logic             align_lost,
  input logic             cause_clr,
  input logic             link_up,
  input logic             link_rst,
  input logic             peer_rst_out,
  input logic [5:0]       fail_cause
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= 0;
    else if (peer_rst_out) run_q <= run_q + 1;
    else                   run_q <= 0;
  end

  // R6: the fail cycle is always followed by the reset hold
  assert_fail_then_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_rst && !peer_rst_out) |=> (link_rst && peer_rst_out));

  // R6: reset request only while the local reset is held
  assert_req_inside_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    peer_rst_out |-> (link_rst && !link_up));

  // R7: request length equals the hold
  assert_hold_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(peer_rst_out) |-> (run_q == HOLD_CYC));

  assert_hold_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= HOLD_CYC);

  // R8: link comes up only after all lanes were in sync
  assert_up_needs_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(&lane_sync));

  // R10: failures only start from the up state
  assert_fail_from_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_rst) |-> $past(link_up));

  // R5: alignment loss while up trips the link
  assert_align_trips_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && align_lost) |=> (link_rst && !peer_rst_out));

  // R11: cause only moves at failure entry or on a clear
  assert_cause_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fail_cause) |-> ($rose(link_rst) || $past(cause_clr)));
endmodule

bind lnk_fail_mon lfm_chk #(
  .LANES(LANES),
  .HOLD_CYC(HOLD_CYC)
) u_lfm_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lane_sync    (lane_sync),
  .align_lost   (align_lost),
  .cause_clr    (cause_clr),
  .link_up      (link_up),
  .link_rst     (link_rst),
  .peer_rst_out (peer_rst_out),
  .fail_cause   (fail_cause)
);

// File: tb/test_lnk_fail_mon.sv
module test_lnk_fail_mon;
  localparam int LANES = 4;
  localparam int CNT_W = 8;
  localparam int WIN_W = 16;
  localparam int HOLD  = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LANES-1:0] lane_cv, lane_sync;
  logic             align_lost, tx_fifo_ovf, rx_fifo_ovf, bad_k_req, peer_rst_in;
  logic [CNT_W-1:0] err_thresh;
  logic [WIN_W-1:0] clean_win;
  logic             cause_clr;
  logic             link_up, link_rst, peer_rst_out;
  logic [5:0]       fail_cause;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  lnk_fail_mon #(
    .LANES(LANES), .CNT_W(CNT_W), .WIN_W(WIN_W), .HOLD_CYC(HOLD)
  ) i_lnk_fail_mon (
    .clk(clk), .rst_n(rst_n), .lane_cv(lane_cv), .lane_sync(lane_sync),
    .align_lost(align_lost), .tx_fifo_ovf(tx_fifo_ovf), .rx_fifo_ovf(rx_fifo_ovf),
    .bad_k_req(bad_k_req), .peer_rst_in(peer_rst_in), .err_thresh(err_thresh),
    .clean_win(clean_win), .cause_clr(cause_clr), .link_up(link_up),
    .link_rst(link_rst), .peer_rst_out(peer_rst_out), .fail_cause(fail_cause)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bring_up();
    lane_sync = '1;
    for (int i = 0; i < 60 && !link_up; i++) step(1);
  endtask

  task automatic wait_obs(input int n, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (link_rst) seen = 1'b1;
    end
  endtask

  task automatic inject(input int k);
    for (int i = 0; i < k; i++) begin
      lane_cv = LANES'(1 << (i % LANES));
      step(1);
    end
    lane_cv = '0;
  endtask

  task automatic set_src(input int idx, input logic v);
    case (idx)
      1: align_lost  = v;
      2: tx_fifo_ovf = v;
      3: rx_fifo_ovf = v;
      4: bad_k_req   = v;
      5: peer_rst_in = v;
      default: ;
    endcase
  endtask

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    int n;
    rst_n = 1'b0;
    lane_cv = '0; lane_sync = '0;
    align_lost = 0; tx_fifo_ovf = 0; rx_fifo_ovf = 0; bad_k_req = 0; peer_rst_in = 0;
    err_thresh = 8'd3; clean_win = 16'd8; cause_clr = 0;
    step(3);
    chk("R1 link_up in reset", link_up, 0);
    chk("R1 link_rst in reset", link_rst, 0);
    chk("R1 peer_rst_out in reset", peer_rst_out, 0);
    chk("R1 cause in reset", fail_cause, 0);
    rst_n = 1'b1;
    step(3);
    chk("R1 R8 no sync stays down", link_up, 0);
    chk("R1 link_rst after release", link_rst, 0);
    bring_up();
    chk("R8 up once synced", link_up, 1);

    // R2 sweep of thresholds against error counts
    for (int t = 0; t <= 4; t++) begin
      for (int k = 0; k <= t + 2; k++) begin
        err_thresh = CNT_W'(t);
        bring_up();
        inject(k);
        wait_obs(4, seen);
        chk($sformatf("R2 thresh=%0d errs=%0d", t, k), seen, (k > t) ? 1 : 0);
        if (seen) begin
          bring_up();
          chk("R11 count cause bit", fail_cause, 1);
        end else begin
          step(10);
        end
      end
    end

    // R2 several lanes in one cycle
    err_thresh = 8'd3; bring_up();
    lane_cv = 4'b1111; step(1); lane_cv = '0;
    wait_obs(4, seen); chk("R2 four lanes thresh 3", seen, 1);
    bring_up();
    err_thresh = 8'd4;
    lane_cv = 4'b1111; step(1); lane_cv = '0;
    wait_obs(4, seen); chk("R2 four lanes thresh 4", seen, 0);
    step(10);
    err_thresh = 8'd3;
    lane_cv = 4'b0101; step(2); lane_cv = '0;
    wait_obs(4, seen); chk("R2 two lanes two cycles", seen, 1);
    bring_up();

    // R3 saturation
    err_thresh = 8'd254;
    lane_cv = '1; step(64); lane_cv = '0;
    wait_obs(4, seen); chk("R3 saturate trips 254", seen, 1);
    bring_up();
    err_thresh = 8'd255;
    lane_cv = '1; step(70); lane_cv = '0;
    wait_obs(4, seen); chk("R3 never past 255", seen, 0);
    step(10);

    // R4 error-free window
    err_thresh = 8'd2; clean_win = 16'd8;
    inject(2); step(8); inject(1);
    wait_obs(4, seen); chk("R4 window of 8 clears", seen, 0);
    step(10);
    inject(2); step(7); inject(1);
    wait_obs(4, seen); chk("R4 window of 7 keeps", seen, 1);
    bring_up();
    clean_win = 16'd0;
    inject(2); step(40); inject(1);
    wait_obs(4, seen); chk("R4 zero window never clears", seen, 1);
    bring_up();
    clean_win = 16'd8; err_thresh = 8'd200;

    // R6 R7 R8 sequence timing
    lane_sync = 4'b1011;
    set_src(1, 1); step(1); set_src(1, 0);
    chk("R6 fail state link_rst", link_rst, 1);
    chk("R6 fail state no request", peer_rst_out, 0);
    step(1);
    n = 0;
    while (peer_rst_out && n < 40) begin
      if (!link_rst) chk("R6 rst held in hold", link_rst, 1);
      n++;
      step(1);
    end
    chk("R7 request length", n, HOLD);
    chk("R6 rst released", link_rst, 0);
    chk("R6 not up in sync wait", link_up, 0);
    step(10);
    chk("R8 partial sync stays down", link_up, 0);
    lane_sync = '1; step(1);
    chk("R8 up after full sync", link_up, 1);

    // R5 R9 R11 each source alone
    for (int idx = 1; idx <= 5; idx++) begin
      bring_up();
      set_src(idx, 1); step(1); set_src(idx, 0);
      chk($sformatf("R5 R9 source %0d trips", idx), link_rst, 1);
      bring_up();
      chk($sformatf("R11 cause source %0d", idx), fail_cause, 1 << idx);
    end

    // R11 two sources together
    tx_fifo_ovf = 1; rx_fifo_ovf = 1; step(1);
    tx_fifo_ovf = 0; rx_fifo_ovf = 0;
    bring_up(); step(5);
    chk("R11 two sources", fail_cause, 12);

    // R12 clear, then capture beats clear
    cause_clr = 1; step(1); cause_clr = 0;
    chk("R12 clear", fail_cause, 0);
    align_lost = 1; cause_clr = 1; step(1);
    align_lost = 0; cause_clr = 0;
    bring_up(); step(5);
    chk("R12 capture wins", fail_cause, 2);

    // R10 conditions ignored outside up
    lane_sync = '0;
    tx_fifo_ovf = 1; step(1); tx_fifo_ovf = 0;
    step(25);
    chk("R10 in sync wait", link_up + link_rst, 0);
    err_thresh = 8'd0;
    align_lost = 1; tx_fifo_ovf = 1; rx_fifo_ovf = 1; bad_k_req = 1; peer_rst_in = 1;
    lane_cv = '1;
    step(5);
    align_lost = 0; tx_fifo_ovf = 0; rx_fifo_ovf = 0; bad_k_req = 0; peer_rst_in = 0;
    lane_cv = '0;
    chk("R10 no reset outside up", link_rst, 0);
    chk("R10 cause unchanged", fail_cause, 4);
    lane_sync = '1; step(1);
    chk("R10 comes up", link_up, 1);
    wait_obs(5, seen);
    chk("R10 count held clear", seen, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule